// File: doc/BRIEF.md
# Bus-Clamped Space-Vector Gate Modulator

This block drives the three inverter legs of a voltage-source inverter with a discontinuous (bus-clamped) space-vector pattern. It accepts the sector number of the reference vector and its two orthogonal components, `vd_in` and `vq_in`. Both components are given in carrier counts, because the ratio of period to DC-link voltage is normalised to one. From these inputs it derives two compare levels, called level A and level B. An internal symmetric up/down carrier is compared against the two levels. In every sector one leg is tied to a rail for the whole period, so each period holds a single null state and the leg pattern runs symmetrically in five segments.

The sector, level A and level B are captured together only when the carrier arrives at its top or its bottom. A reference or sector change in the middle of a slope therefore never cuts a pulse short. The three gate outputs are decoded from this captured state and from the carrier register only, so they change only on the clock edges where the carrier moves. Sector finding, reference generation and dead-time insertion are done by neighbouring blocks.

Top module: `busclamp_svm`

## Requirements
- R1: After reset `carrier_out` is 0 and rising. It moves by one count every DIV clocks and reverses when it arrives at PEAK or at 0, so a full period lasts 2·PEAK·DIV clocks.
- R2: From reset until the carrier first arrives at PEAK, all three gates are 0.
- R3: Sector and reference inputs are sampled only on the clock edge where the carrier arrives at PEAK or at 0. A change at any other time has no effect on the gates until that edge.
- R4: Sector codes 1 to 6 are valid. If the code is 0 or 7 on a capture edge, the capture is skipped and the previously captured sector and levels stay in force.
- R5: Three scaled terms are formed as floor(vq·591/1024), floor(vq·1183/1024) and floor(vq·1774/1024), named t1, t2 and t3 (roughly 0.577, 1.155 and 1.732 times vq).
- R6: Levels (A, B) per sector: 1 → (vd−t1, vd+t1); 2 → (vd+t1, t3); 3 → (−vd−t1, −vd+t1); 4 → (−vd+t1, −t2); 5 → (−t3, vd−t1); 6 → (−vd−t1, t2).
- R7: Each level is saturated to the range 0 to PEAK before it is captured.
- R8: In odd sectors the clamped leg is 1. A modulated leg is 1 when carrier ≥ its level.
- R9: In even sectors the clamped leg is 0. A modulated leg is 1 when (PEAK − carrier) ≥ its level.
- R10: Leg roles are (clamped, uses A, uses B): sectors 1 and 4 → (a, b, c); sectors 2 and 5 → (c, a, b); sectors 3 and 6 → (b, c, a).
- R11: A gate never changes in a cycle where the carrier holds. Between two capture edges each leg toggles at most once. With fixed inputs the clamped leg never toggles and each other leg toggles at most twice per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sector_in | input | 3 | Sector code of the reference, 1 to 6 |
| vd_in | input | DW | Signed in-phase reference component, in carrier counts |
| vq_in | input | DW | Signed quadrature reference component, in carrier counts |
| carrier_out | output | clog2(PEAK+1) | Present triangle carrier value |
| gate_a | output | 1 | Leg a gate command |
| gate_b | output | 1 | Leg b gate command |
| gate_c | output | 1 | Leg c gate command |

## Verification
The checker watches these properties on every cycle:
- the carrier stays inside its range and moves by at most one count per cycle;
- the gates hold while the carrier holds;
- each leg toggles at most once per half period;
- the gates stay low before the first capture;
- an invalid sector code leaves the captured sector unchanged.

Some behaviour can only be shown by the bench scenarios. These are the numeric level table with its floor rounding and saturation, the mapping of leg roles to sectors, and the polarity of each compare. Another is that a reference changed in mid-slope takes effect exactly at the next carrier turn and not earlier.

// File: rtl/busclamp_svm_pkg.sv
package busclamp_svm_pkg;

  // Fixed-point coefficients (value / 2^KSH)
  localparam int KSH = 10;
  localparam int K_T1 = 591;   // ~0.577
  localparam int K_T2 = 1183;  // ~1.155
  localparam int K_T3 = 1774;  // ~1.732

  typedef struct packed {
    logic signed [31:0] a;
    logic signed [31:0] b;
  } lvl_pair_t;

  function automatic int scale_term(int v, int k);
    return (v * k) >>> KSH;
  endfunction

  function automatic logic sector_ok(logic [2:0] sec);
    return (sec != 3'd0) && (sec != 3'd7);
  endfunction

  // Unsaturated compare levels for one sector
  function automatic lvl_pair_t sector_levels(logic [2:0] sec, int vd, int vq);
    lvl_pair_t r;
    int t1, t2, t3;
    t1 = scale_term(vq, K_T1);
    t2 = scale_term(vq, K_T2);
    t3 = scale_term(vq, K_T3);
    r = '0;
    case (sec)
      3'd1: begin r.a = vd - t1;  r.b = vd + t1;  end
      3'd2: begin r.a = vd + t1;  r.b = t3;       end
      3'd3: begin r.a = -vd - t1; r.b = -vd + t1; end
      3'd4: begin r.a = -vd + t1; r.b = -t2;      end
      3'd5: begin r.a = -t3;      r.b = vd - t1;  end
      3'd6: begin r.a = -vd - t1; r.b = t2;       end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic int clip(int x, int hi);
    if (x < 0) return 0;
    if (x > hi) return hi;
    return x;
  endfunction

  // Index of the leg tied to a rail: 0=a, 1=b, 2=c
  function automatic int clamp_leg(logic [2:0] sec);
    case (sec)
      3'd1, 3'd4: return 0;
      3'd2, 3'd5: return 2;
      3'd3, 3'd6: return 1;
      default:    return 0;
    endcase
  endfunction

  // Role of a leg: 0 = clamped, 1 = follows level A, 2 = follows level B
  function automatic logic [1:0] leg_role(logic [2:0] sec, int leg);
    int d;
    d = (leg + 3 - clamp_leg(sec)) % 3;
    return 2'(d);
  endfunction

endpackage

// File: rtl/svm_carrier.sv
module svm_carrier #(
  parameter int PEAK = 16,
  parameter int DIV  = 13,
  localparam int CW  = $clog2(PEAK + 1),
  localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          turn
);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;
  logic          up_q;
  logic          step;
  logic          hit_top;
  logic          hit_bot;

  assign step    = (pre_q == PW'(DIV - 1));
  assign hit_top = up_q && (cnt_q == CW'(PEAK - 1));
  assign hit_bot = !up_q && (cnt_q == CW'(1));
  assign turn    = step && (hit_top || hit_bot);
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (step) begin
      pre_q <= '0;
      if (up_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (hit_top) up_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (hit_bot) up_q <= 1'b1;
      end
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/svm_level_calc.sv
module svm_level_calc
  import busclamp_svm_pkg::*;
#(
  parameter int DW   = 12,
  parameter int PEAK = 16,
  localparam int CW  = $clog2(PEAK + 1)
) (
  input  logic [2:0]           sector,
  input  logic signed [DW-1:0] vd,
  input  logic signed [DW-1:0] vq,
  output logic [CW-1:0]        lvl_a,
  output logic [CW-1:0]        lvl_b,
  output logic                 sec_ok
);

  lvl_pair_t raw;

  assign raw    = sector_levels(sector, int'(vd), int'(vq));
  assign lvl_a  = CW'(clip(int'(raw.a), PEAK));
  assign lvl_b  = CW'(clip(int'(raw.b), PEAK));
  assign sec_ok = sector_ok(sector);

endmodule

// File: rtl/svm_gate_mux.sv
module svm_gate_mux
  import busclamp_svm_pkg::*;
#(
  parameter int PEAK = 16,
  localparam int CW  = $clog2(PEAK + 1)
) (
  input  logic [2:0]    sect,
  input  logic [CW-1:0] lvl_a,
  input  logic [CW-1:0] lvl_b,
  input  logic [CW-1:0] cnt,
  input  logic          en,
  output logic [2:0]    gates
);

  logic          odd;
  logic [CW-1:0] cnt_inv;

  assign odd     = sect[0];
  assign cnt_inv = CW'(PEAK) - cnt;

  for (genvar g = 0; g < 3; g++) begin : g_leg
    logic [1:0]    role;
    logic [CW-1:0] lvl;
    logic          cmp;
    assign role     = leg_role(sect, g);
    assign lvl      = (role == 2'd1) ? lvl_a : lvl_b;
    assign cmp      = odd ? (cnt >= lvl) : (cnt_inv >= lvl);
    assign gates[g] = en & ((role == 2'd0) ? odd : cmp);
  end

endmodule

// File: rtl/busclamp_svm.sv
module busclamp_svm
  import busclamp_svm_pkg::*;
#(
  parameter int DW   = 12,
  parameter int PEAK = 16,
  parameter int DIV  = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2:0]                  sector_in,
  input  logic signed [DW-1:0]        vd_in,
  input  logic signed [DW-1:0]        vq_in,
  output logic [$clog2(PEAK+1)-1:0]   carrier_out,
  output logic                        gate_a,
  output logic                        gate_b,
  output logic                        gate_c
);

  localparam int CW = $clog2(PEAK + 1);

  logic [CW-1:0] cnt;
  logic          turn_evt;
  logic [CW-1:0] lvl_a_d, lvl_b_d;
  logic          sec_ok;
  logic [CW-1:0] lvl_a_q, lvl_b_q;
  logic [2:0]    sect_q;
  logic          armed_q;
  logic [2:0]    gates;

  svm_carrier #(.PEAK(PEAK), .DIV(DIV)) u_carrier (
    .clk  (clk),
    .rst_n(rst_n),
    .cnt  (cnt),
    .turn (turn_evt)
  );

  svm_level_calc #(.DW(DW), .PEAK(PEAK)) u_levels (
    .sector(sector_in),
    .vd    (vd_in),
    .vq    (vq_in),
    .lvl_a (lvl_a_d),
    .lvl_b (lvl_b_d),
    .sec_ok(sec_ok)
  );

  // Capture only at the carrier turning points
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sect_q  <= 3'd1;
      lvl_a_q <= '0;
      lvl_b_q <= '0;
      armed_q <= 1'b0;
    end else if (turn_evt && sec_ok) begin
      sect_q  <= sector_in;
      lvl_a_q <= lvl_a_d;
      lvl_b_q <= lvl_b_d;
      armed_q <= 1'b1;
    end
  end

  svm_gate_mux #(.PEAK(PEAK)) u_mux (
    .sect (sect_q),
    .lvl_a(lvl_a_q),
    .lvl_b(lvl_b_q),
    .cnt  (cnt),
    .en   (armed_q),
    .gates(gates)
  );

  assign carrier_out = cnt;
  assign gate_a      = gates[0];
  assign gate_b      = gates[1];
  assign gate_c      = gates[2];

endmodule

// File: rtl/busclamp_svm_chk.sv
module busclamp_svm_chk #(
  parameter int PEAK = 16,
  localparam int CW  = $clog2(PEAK + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] carrier,
  input logic [2:0]    gates,
  input logic          turn_evt,
  input logic          sec_ok,
  input logic [2:0]    sect_q,
  input logic          armed_q
);

  logic [2:0]      gates_prev;
  logic            latched_prev;
  logic [1:0]      tog_cnt [3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gates_prev   <= '0;
      latched_prev <= 1'b0;
      for (int g = 0; g < 3; g++) tog_cnt[g] <= '0;
    end else begin
      gates_prev   <= gates;
      latched_prev <= turn_evt;
      for (int g = 0; g < 3; g++) begin
        if (latched_prev) tog_cnt[g] <= '0;
        else if ((gates[g] != gates_prev[g]) && (tog_cnt[g] != 2'd3))
          tog_cnt[g] <= tog_cnt[g] + 1'b1;
      end
    end
  end

  // R1
  carrier_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, carrier} <= (CW+1)'(PEAK));

  // R1
  carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (carrier == $past(carrier)) ||
             ({1'b0, carrier} == {1'b0, $past(carrier)} + 1'b1) ||
             ({1'b0, carrier} + 1'b1 == {1'b0, $past(carrier)}));

  // R11
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(carrier) |-> $stable(gates));

  // R11
  half_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_cnt[0] <= 2'd1) && (tog_cnt[1] <= 2'd1) && (tog_cnt[2] <= 2'd1));

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (gates == 3'b000));

  // R4
  bad_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_evt && !sec_ok) |=> $stable(sect_q));

endmodule

bind busclamp_svm busclamp_svm_chk #(.PEAK(PEAK)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .carrier (carrier_out),
  .gates   (gates),
  .turn_evt(turn_evt),
  .sec_ok  (sec_ok),
  .sect_q  (sect_q),
  .armed_q (armed_q)
);

// File: tb/busclamp_svm_test.sv
`timescale 1ns/1ps
module busclamp_svm_test;

  localparam int DW   = 12;
  localparam int PEAK = 16;
  localparam int DIV  = 3;
  localparam int CW   = $clog2(PEAK + 1);
  localparam int PER  = 2 * PEAK * DIV;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [2:0]           sector_in = 3'd1;
  logic signed [DW-1:0] vd_in = '0;
  logic signed [DW-1:0] vq_in = '0;
  logic [CW-1:0]        carrier_out;
  logic                 gate_a, gate_b, gate_c;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  busclamp_svm #(.DW(DW), .PEAK(PEAK), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .sector_in(sector_in), .vd_in(vd_in), .vq_in(vq_in),
    .carrier_out(carrier_out), .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c)
  );

  // ---------------- reference model ----------------
  function automatic int fl_scale(int v, int k);
    int p;
    p = v * k;
    if (p >= 0) return p / 1024;
    return -((-p + 1023) / 1024);
  endfunction

  function automatic int ref_level(int sec, int vd, int vq, bit want_b);
    int t1, t2, t3, la, lb;
    t1 = fl_scale(vq, 591);
    t2 = fl_scale(vq, 1183);
    t3 = fl_scale(vq, 1774);
    la = 0; lb = 0;
    if (sec == 1) begin la = vd - t1;  lb = vd + t1;  end
    if (sec == 2) begin la = vd + t1;  lb = t3;       end
    if (sec == 3) begin la = -vd - t1; lb = -vd + t1; end
    if (sec == 4) begin la = -vd + t1; lb = -t2;      end
    if (sec == 5) begin la = -t3;      lb = vd - t1;  end
    if (sec == 6) begin la = -vd - t1; lb = t2;       end
    if (want_b) la = lb;
    if (la < 0) la = 0;
    if (la > PEAK) la = PEAK;
    return la;
  endfunction

  function automatic bit ref_gate(int sec, int vd, int vq, int leg, int car);
    int cl, lv;
    bit odd;
    cl = (sec == 1 || sec == 4) ? 0 : ((sec == 2 || sec == 5) ? 2 : 1);
    odd = (sec % 2) == 1;
    if (leg == cl) return odd;
    lv = ref_level(sec, vd, vq, leg == (cl + 2) % 3);
    if (odd) return car >= lv;
    return (PEAK - car) >= lv;
  endfunction

  function automatic int ref_gates(int sec, int vd, int vq, int car);
    return {ref_gate(sec, vd, vq, 2, car), ref_gate(sec, vd, vq, 1, car),
            ref_gate(sec, vd, vq, 0, car)};
  endfunction

  function automatic int dut_gates();
    return {gate_c, gate_b, gate_a};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(int sec, int vd, int vq);
    sector_in = 3'(sec);
    vd_in     = DW'(vd);
    vq_in     = DW'(vq);
  endtask

  // Run until a capture edge has taken the present inputs (ends on a bottom arrival)
  task automatic settle();
    while (int'(carrier_out) != PEAK) @(negedge clk);
    while (int'(carrier_out) != 0) @(negedge clk);
  endtask

  // Compare one full period against the model; count toggles per leg
  task automatic compare_period(int sec, int vd, int vq, string req,
                                output int miss, output int tog_max, output int tog_cl);
    int prev, cur, cl;
    int tog [3];
    miss = 0;
    tog = '{0, 0, 0};
    cl = (sec == 1 || sec == 4) ? 0 : ((sec == 2 || sec == 5) ? 2 : 1);
    prev = dut_gates();
    for (int i = 0; i < PER; i++) begin
      cur = dut_gates();
      if (cur != ref_gates(sec, vd, vq, int'(carrier_out))) begin
        if (miss == 0)
          $display("  %s mismatch at carrier=%0d", req, int'(carrier_out));
        miss++;
      end
      for (int g = 0; g < 3; g++) if (cur[g] != prev[g]) tog[g]++;
      prev = cur;
      @(negedge clk);
    end
    tog_cl = tog[cl];
    tog_max = 0;
    for (int g = 0; g < 3; g++) if (tog[g] > tog_max) tog_max = tog[g];
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    int nz;
    drive(1, 8, 6);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(int'(carrier_out) == 0 || int'(carrier_out) == 1, "R1 carrier at reset",
          int'(carrier_out), 0);
    check(dut_gates() == 0, "R2 gates low after reset", dut_gates(), 0);
    nz = 0;
    while (int'(carrier_out) != PEAK) begin
      if (dut_gates() != 0) nz++;
      @(negedge clk);
    end
    check(nz == 0, "R2 gates low before first top", nz, 0);
  endtask

  task automatic t_period();
    int n;
    while (int'(carrier_out) == 0) @(negedge clk);
    while (int'(carrier_out) != 0) @(negedge clk);
    n = 0;
    while (int'(carrier_out) == 0) begin n++; @(negedge clk); end
    while (int'(carrier_out) != 0) begin n++; @(negedge clk); end
    check(n == PER, "R1 carrier period", n, PER);
  endtask

  task automatic t_sector(int sec, int vd, int vq, string req);
    int miss, tmax, tcl;
    drive(sec, vd, vq);
    settle();
    compare_period(sec, vd, vq, req, miss, tmax, tcl);
    check(miss == 0, req, miss, 0);
    check(tcl == 0 && tmax <= 2, "R11 toggles per period", tcl * 10 + tmax, 2);
  endtask

  task automatic t_bad_sector();
    int miss, tmax, tcl;
    drive(1, 8, 6);
    settle();
    drive(7, -8, 3);
    settle();
    compare_period(1, 8, 6, "R4 code 7", miss, tmax, tcl);
    check(miss == 0, "R4 code 7 ignored", miss, 0);
    drive(0, 2, -9);
    settle();
    compare_period(1, 8, 6, "R4 code 0", miss, tmax, tcl);
    check(miss == 0, "R4 code 0 ignored", miss, 0);
  endtask

  task automatic t_mid_slope();
    int m_old, m_new;
    drive(1, 8, 6);
    settle();
    while (int'(carrier_out) != PEAK / 2) @(negedge clk);
    drive(2, 2, 6);
    m_old = 0;
    m_new = 0;
    @(negedge clk);
    while (int'(carrier_out) != PEAK) begin
      if (dut_gates() != ref_gates(1, 8, 6, int'(carrier_out))) m_old++;
      @(negedge clk);
    end
    for (int i = 0; i < PEAK * DIV; i++) begin
      if (dut_gates() != ref_gates(2, 2, 6, int'(carrier_out))) m_new++;
      @(negedge clk);
    end
    check(m_old == 0, "R3 old levels held mid-slope", m_old, 0);
    check(m_new == 0, "R3 new levels from top", m_new, 0);
  endtask

  initial begin
    t_reset();
    t_period();
    t_sector(1, 8, 6,   "R6 R8 R10 sector1");
    t_sector(2, 2, 6,   "R6 R9 R10 sector2");
    t_sector(3, -9, -4, "R5 R6 R8 sector3");
    t_sector(4, -5, -7, "R5 R6 R9 sector4");
    t_sector(5, 7, -5,  "R5 R6 R8 sector5");
    t_sector(6, -3, 9,  "R6 R7 R9 sector6");
    t_sector(1, 100, 0, "R7 saturate high");
    t_sector(4, 60, 0,  "R7 saturate low");
    t_bad_sector();
    t_mid_slope();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule